// File: doc/BRIEF.md
# Moore serial pattern detector

This block watches a single serial data line, taking one bit on each rising clock edge. It flags the arrival of the seven-bit sequence 0000111, where the leftmost bit is received first. It is a Moore machine. The flag is decoded from the current state alone, so it rises in the clock cycle that follows the edge on which the final `1` of the sequence was sampled.

The machine has eight states held in a three-bit register. The binary value of each state equals its index, and that code is driven out on `state_code`. Each state records how many leading bits of the sequence the recent input has matched:

| State | Code | Matched so far |
|---|---|---|
| ST_IDLE | 000 | nothing useful |
| ST_Z1 | 001 | 0 |
| ST_Z2 | 010 | 00 |
| ST_Z3 | 011 | 000 |
| ST_Z4 | 100 | 0000 |
| ST_O1 | 101 | 00001 |
| ST_O2 | 110 | 000011 |
| ST_HIT | 111 | 0000111 |

The transitions are:

| Current state | Input 0 | Input 1 |
|---|---|---|
| ST_IDLE, ST_Z1, ST_Z2, ST_Z3 | advance one state | ST_IDLE |
| ST_Z4 | ST_Z4 | ST_O1 |
| ST_O1, ST_O2 | ST_Z1 | advance one state |
| ST_HIT | ST_Z1 | ST_IDLE |

A synchronous, active-high reset returns the machine to ST_IDLE.

Top module: `seq7_watch`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is code 000 whatever `bit_in` is. In that state `found` is 0.
- R2: `state_code` equals the number of leading bits of 0000111 that the input since reset has matched. This is the longest suffix of that input which is also a prefix of the sequence. Codes 000 to 111 stand for 0 to 7 matched bits.
- R3: `found` is 1 exactly when `state_code` is 111, and it depends on nothing else.
- R4: `found` is 1 in the cycle after the edge that samples the last bit of 0000111, with bits sampled oldest first.
- R5: In state 100, a 0 keeps the state at 100, so a run of more than four zeros still leads to a detection.
- R6: In states 000 to 011, a 1 moves the machine to 000.
- R7: In states 101, 110 and 111, a 0 moves the machine to 001.
- R8: In state 111, a 1 moves the machine to 000. Because the sequence shares no suffix with its own prefix, each detection after another needs seven fresh bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data, one bit sampled per edge |
| state_code | output | 3 | Current state code (binary index) |
| found | output | 1 | High while the sequence has just been seen |

## Verification
Two things can coincide: a reset can land in the same cycle that a detection would have happened, and the restart that follows a detection meets the first zero of the next sequence. The bench handles the first case by raising `rst` just as the last `1` of a sequence is driven. It expects state 000 and a low flag in the next cycle, not 111. The bench handles the second case by sending sequences back to back, and longer runs of zeros, while comparing state and flag on every cycle. The expected values come from a history-based model that searches for the longest suffix matching a prefix.

// File: rtl/seq7_pkg.sv
package seq7_pkg;
    localparam int STATE_W = 3;
    localparam int SEQ_LEN = 7;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 3'd0,
        ST_Z1   = 3'd1,
        ST_Z2   = 3'd2,
        ST_Z3   = 3'd3,
        ST_Z4   = 3'd4,
        ST_O1   = 3'd5,
        ST_O2   = 3'd6,
        ST_HIT  = 3'd7
    } seq_state_t;
endpackage

// File: rtl/seq7_next_state.sv
module seq7_next_state
    import seq7_pkg::*;
(
    input  seq_state_t cur,
    input  logic       bit_in,
    output seq_state_t nxt
);
    always_comb begin
        nxt = ST_IDLE;
        unique case (cur)
            ST_IDLE: nxt = bit_in ? ST_IDLE : ST_Z1;
            ST_Z1:   nxt = bit_in ? ST_IDLE : ST_Z2;
            ST_Z2:   nxt = bit_in ? ST_IDLE : ST_Z3;
            ST_Z3:   nxt = bit_in ? ST_IDLE : ST_Z4;
            ST_Z4:   nxt = bit_in ? ST_O1   : ST_Z4;
            ST_O1:   nxt = bit_in ? ST_O2   : ST_Z1;
            ST_O2:   nxt = bit_in ? ST_HIT  : ST_Z1;
            ST_HIT:  nxt = bit_in ? ST_IDLE : ST_Z1;
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/seq7_out_decode.sv
module seq7_out_decode
    import seq7_pkg::*;
(
    input  seq_state_t cur,
    output logic       found
);
    always_comb begin
        found = 1'b0;
        unique case (cur)
            ST_HIT:  found = 1'b1;
            default: found = 1'b0;
        endcase
    end
endmodule

// File: rtl/seq7_watch.sv
module seq7_watch
    import seq7_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_in,
    output logic [STATE_W-1:0] state_code,
    output logic               found
);
    seq_state_t state_q;
    seq_state_t state_d;

    seq7_next_state u_next (
        .cur    (state_q),
        .bit_in (bit_in),
        .nxt    (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    seq7_out_decode u_dec (
        .cur   (state_q),
        .found (found)
    );

    assign state_code = state_q;

    AST_RESET_TO_IDLE: assert property (@(posedge clk)
        rst |=> (state_code == 3'd0 && !found)); // R1
    AST_FLAG_MATCHES_HIT: assert property (@(posedge clk) disable iff (rst)
        found == (state_q == ST_HIT)); // R3
    AST_ONE_CLEARS_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (state_q inside {ST_IDLE, ST_Z1, ST_Z2, ST_Z3} && bit_in) |=> state_q == ST_IDLE); // R6
    AST_ZERO_HOLDS_FOUR: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_Z4 && !bit_in) |=> state_q == ST_Z4); // R5
    AST_ZERO_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (state_q inside {ST_O1, ST_O2, ST_HIT} && !bit_in) |=> state_q == ST_Z1); // R7
    AST_HIT_ONE_IDLES: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HIT && bit_in) |=> state_q == ST_IDLE); // R8
endmodule

// File: tb/sim_seq7_watch.sv
module sim_seq7_watch;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0;
    logic [2:0] state_code;
    logic       found;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int seen_bits[$];
    int pat[7] = '{0, 0, 0, 0, 1, 1, 1};

    seq7_watch u0 (
        .clk        (clk),
        .rst        (rst),
        .bit_in     (bit_in),
        .state_code (state_code),
        .found      (found)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int model_state();
        int n = seen_bits.size();
        for (int len = 7; len >= 1; len--) begin
            if (n >= len) begin
                bit ok = 1'b1;
                for (int i = 0; i < len; i++)
                    if (seen_bits[n-len+i] != pat[i]) ok = 1'b0;
                if (ok) return len;
            end
        end
        return 0;
    endfunction

    task automatic check(string tag, int exp_st);
        n_checks++;
        if (state_code !== exp_st[2:0]) begin
            n_fail++;
            $display("FAIL %s state_code actual=%0d expected=%0d", tag, state_code, exp_st);
        end
        n_checks++;
        if (found !== (exp_st == 7)) begin
            n_fail++;
            $display("FAIL %s found actual=%0b expected=%0b", tag, found, exp_st == 7);
        end
    endtask

    task automatic step(logic b, logic r, string tag);
        bit_in = b;
        rst = r;
        @(posedge clk);
        if (r) seen_bits.delete();
        else begin
            seen_bits.push_back(int'(b));
            if (seen_bits.size() > 16) void'(seen_bits.pop_front());
        end
        @(negedge clk);
        check(tag, model_state());
    endtask

    task automatic send_seq(string tag);
        for (int i = 0; i < 7; i++) step(pat[i][0], 1'b0, tag);
    endtask

    initial begin
        @(negedge clk);
        step(1'b1, 1'b1, "R1 reset");
        step(1'b0, 1'b1, "R1 reset");

        send_seq("R4 R2 single");
        send_seq("R8 back-to-back");
        send_seq("R8 back-to-back");
        step(1'b1, 1'b0, "R8 one after hit");
        for (int i = 0; i < 9; i++) step(1'b0, 1'b0, "R5 long zeros");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R5 R4 tail");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R6 prefix");
        step(1'b1, 1'b0, "R6 one in prefix");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R7 prefix");
        step(1'b1, 1'b0, "R7 s5");
        step(1'b0, 1'b0, "R7 zero from s5");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R7 prefix");
        step(1'b1, 1'b0, "R7 s5");
        step(1'b1, 1'b0, "R7 s6");
        step(1'b0, 1'b0, "R7 zero from s6");
        send_seq("R7 R3 pre");
        step(1'b0, 1'b0, "R7 zero from hit");

        for (int i = 0; i < 6; i++) step(pat[i][0], 1'b0, "R1 pre");
        step(1'b1, 1'b1, "R1 reset on last bit");
        step(1'b1, 1'b0, "R1 after reset");

        for (int i = 0; i < 3000; i++)
            step(($urandom % 3) != 0 ? 1'b0 : 1'b1, ($urandom % 500) == 0, "R2 R3 R4 random");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule